// File: doc/BRIEF.md
# Cache Maintenance Operation Controller

This block carries out cache maintenance instructions against a small model of a pair of direct-mapped caches, one for instructions and one for data. Each cache line keeps a tag, a valid bit and a dirty bit. The caches are indexed with virtual address bits and tagged with physical tags. The pipeline presents a 32-bit instruction word with a valid strobe, the virtual address of the operand and the translated physical tag. The controller recognises the maintenance opcode and turns the operation field into a three-bit internal command. That command names the cache, says whether the line is chosen by index or by a tag hit, and says whether a dirty line must be written back first.

The controller then walks a short state machine. It reads the selected line and decides whether the line is affected. If the command asks for write-back and the line is both valid and dirty, it raises a write-back request that carries the line address and holds it until an acknowledge arrives. It then zeroes the line entry and reports completion. Completion comes with a hit indication and, for instruction-cache operations, a pipeline-flush request. The two store-tag operations have zeroed tag staging registers, so they behave as an index invalidate that never writes back. A fill port installs lines so the surrounding pipeline or a bench can populate the model.

Top module: `cache_maint_ctrl`

## Requirements
- R1: A word is taken as a maintenance instruction only when bits [31:26] equal 6'b101111. Any other word is ignored: done and busy stay low and no line changes.
- R2: Bits [20:16] map to the command {data cache, by index, write only} as follows: 00000 and 01000 give 011, 10000 gives 001, 00001 gives 110, 01001 gives 111, 10001 gives 101, and 10101 gives 100. Every other code gives 000, which completes with done one cycle after acceptance, busy never high, done_hit low, no flush and no change to any line.
- R3: An index command (by index = 1) selects the line by vaddr[OFF_W+IDX_W-1:OFF_W] whatever the physical tag. A valid line is cleared. Data Index Writeback Invalid (00001) first writes the line back when it is dirty.
- R4: The store-tag codes 01000 and 01001 clear the indexed line and never raise a write-back request, even for a dirty line.
- R5: A hit command (by index = 0) clears the line only when it is valid and its stored tag equals ptag. On a miss the operation completes with no change. Data Hit Invalid (10001) never writes back.
- R6: Data Hit Writeback Invalid (10101) writes back a hitting line that is dirty and then clears it. A clean hit is cleared without a write-back.
- R7: While wb_req is high, wb_addr = {stored tag, line index, OFF_W zero bits}, and both stay unchanged until the cycle wb_ack is sampled high. At most one write-back is made per operation.
- R8: flush_req is high exactly in the done cycle of an instruction-cache operation (command bit 2 = 0, command not 000) and never otherwise.
- R9: busy is high from the cycle after acceptance until the done cycle, which lasts one cycle. Instructions presented while busy or done are high are ignored.
- R10: Synchronous reset clears every valid and dirty bit in both caches and leaves busy, done, wb_req and flush_req low.
- R11: done_hit in the done cycle is high when the selected line was valid and, for hit commands, its tag matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr | input | 32 | Instruction word |
| vaddr | input | VADDR_W | Virtual address of the operand |
| ptag | input | TAG_W | Translated physical tag of the operand |
| fill_en | input | 1 | Install a line this cycle |
| fill_dcache | input | 1 | Fill target: 0 instruction cache, 1 data cache |
| fill_vaddr | input | VADDR_W | Virtual address giving the fill index |
| fill_ptag | input | TAG_W | Tag written by the fill |
| fill_dirty | input | 1 | Dirty bit written by the fill |
| wb_ack | input | 1 | One-cycle acknowledge of the write-back |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | Line was affected (valid, and tag matched for hit commands) |
| flush_req | output | 1 | Pipeline-flush request at instruction-cache completion |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | TAG_W+IDX_W+OFF_W | Line address for the write-back |

## Verification
The bench aims at the boundary between index and hit addressing. It installs a line and then issues a hit command with a different tag. A design that ignores the tag would clear the line and the later write-back would never come. Store-tag codes are issued against dirty lines, where a design that treats them like the write-back index form would raise a request. A clean hit under Hit Writeback Invalid, unsupported codes and a wrong major opcode are exercised too: the first must not write back, and the other two must leave the model untouched. A second command is injected while a delayed acknowledge is pending. A design that accepted it would clear a line that a later operation still expects to find dirty. Random operations with late acknowledges compare wb_addr, done_hit and flush_req against a bench model of both caches.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    localparam logic [5:0] CMO_OPCODE = 6'b101111;

    typedef struct packed {
        logic dcache;      // 1 = data cache
        logic by_index;    // 1 = select by index, 0 = by tag hit
        logic write_only;  // 1 = no write-back
    } cmo_cmd_t;

    localparam cmo_cmd_t CMD_NOP = '{dcache: 1'b0, by_index: 1'b0, write_only: 1'b0};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRITEBACK,
        ST_CLEAR,
        ST_DONE
    } cmo_state_e;

    function automatic cmo_cmd_t cmo_map_op(input logic [4:0] sel);
        cmo_cmd_t c;
        case (sel)
            5'b00000, 5'b01000: c = 3'b011;
            5'b10000:           c = 3'b001;
            5'b00001:           c = 3'b110;
            5'b01001:           c = 3'b111;
            5'b10001:           c = 3'b101;
            5'b10101:           c = 3'b100;
            default:            c = CMD_NOP;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cmo_decode.sv
module cmo_decode
    import cmo_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [4:0] op_sel,
    output logic       is_cmo,
    output cmo_cmd_t   cmd
);
    assign is_cmo = (opcode == CMO_OPCODE);
    assign cmd    = is_cmo ? cmo_map_op(op_sel) : CMD_NOP;
endmodule

// File: rtl/cmo_tag_store.sv
module cmo_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
            end
        end else begin
            if (fill_en) begin
                valid_q[fill_idx] <= 1'b1;
                dirty_q[fill_idx] <= fill_dirty;
                tag_q[fill_idx]   <= fill_tag;
            end
            if (clr_en) begin
                valid_q[clr_idx] <= 1'b0;
                dirty_q[clr_idx] <= 1'b0;
                tag_q[clr_idx]   <= '0;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !valid_q[$past(clr_idx)] && !dirty_q[$past(clr_idx)]); // R3
    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (valid_q == '0) && (dirty_q == '0)); // R10
endmodule

// File: rtl/cmo_fsm.sv
module cmo_fsm
    import cmo_pkg::*;
#(
    parameter int TAG_W = 20,
    parameter int IDX_W = 4,
    parameter int OFF_W = 4,
    localparam int PADDR_W = TAG_W + IDX_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic               is_cmo,
    input  cmo_cmd_t           cmd_in,
    input  logic [IDX_W-1:0]   idx_in,
    input  logic [TAG_W-1:0]   ptag_in,
    input  logic               rd_valid,
    input  logic               rd_dirty,
    input  logic [TAG_W-1:0]   rd_tag,
    input  logic               wb_ack,
    output logic [IDX_W-1:0]   line_idx,
    output logic               sel_dcache,
    output logic               clr_en,
    output logic               busy,
    output logic               done,
    output logic               done_hit,
    output logic               flush_req,
    output logic               wb_req,
    output logic [PADDR_W-1:0] wb_addr
);
    cmo_state_e         state_q;
    cmo_cmd_t           cmd_q;
    logic [IDX_W-1:0]   idx_q;
    logic [TAG_W-1:0]   tag_q;
    logic               hit_q;
    logic [PADDR_W-1:0] wb_addr_q;
    logic               start;
    logic               hit_now;

    assign start   = instr_valid && is_cmo && (state_q == ST_IDLE);
    assign hit_now = rd_valid && (cmd_q.by_index || (rd_tag == tag_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cmd_q     <= CMD_NOP;
            idx_q     <= '0;
            tag_q     <= '0;
            hit_q     <= 1'b0;
            wb_addr_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cmd_q   <= cmd_in;
                        idx_q   <= idx_in;
                        tag_q   <= ptag_in;
                        hit_q   <= 1'b0;
                        state_q <= (cmd_in == CMD_NOP) ? ST_DONE : ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    hit_q <= hit_now;
                    if (hit_now && !cmd_q.write_only && rd_dirty) begin
                        wb_addr_q <= {rd_tag, idx_q, {OFF_W{1'b0}}};
                        state_q   <= ST_WRITEBACK;
                    end else if (hit_now) begin
                        state_q <= ST_CLEAR;
                    end else begin
                        state_q <= ST_DONE;
                    end
                end
                ST_WRITEBACK: begin
                    if (wb_ack) begin
                        state_q <= ST_CLEAR;
                    end
                end
                ST_CLEAR: state_q <= ST_DONE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign line_idx   = idx_q;
    assign sel_dcache = cmd_q.dcache;
    assign clr_en     = (state_q == ST_CLEAR);
    assign busy       = (state_q == ST_LOOKUP) || (state_q == ST_WRITEBACK) || (state_q == ST_CLEAR);
    assign done       = (state_q == ST_DONE);
    assign done_hit   = done && hit_q;
    assign flush_req  = done && (cmd_q != CMD_NOP) && !cmd_q.dcache;
    assign wb_req     = (state_q == ST_WRITEBACK);
    assign wb_addr    = wb_addr_q;

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        wb_req && !wb_ack |=> wb_req && $stable(wb_addr)); // R7
    AST_WB_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> cmd_q.dcache && !cmd_q.write_only); // R4
    AST_FLUSH_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> done); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy); // R9
    AST_NOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start && (cmd_in == CMD_NOP) |=> done && !busy && !done_hit); // R2
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        busy |=> busy || done); // R9
endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
    import cmo_pkg::*;
#(
    parameter int LINES      = 16,
    parameter int LINE_BYTES = 16,
    parameter int TAG_W      = 20,
    parameter int VADDR_W    = 32,
    localparam int IDX_W   = $clog2(LINES),
    localparam int OFF_W   = $clog2(LINE_BYTES),
    localparam int PADDR_W = TAG_W + IDX_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [31:0]        instr,
    input  logic [VADDR_W-1:0] vaddr,
    input  logic [TAG_W-1:0]   ptag,
    input  logic               fill_en,
    input  logic               fill_dcache,
    input  logic [VADDR_W-1:0] fill_vaddr,
    input  logic [TAG_W-1:0]   fill_ptag,
    input  logic               fill_dirty,
    input  logic               wb_ack,
    output logic               busy,
    output logic               done,
    output logic               done_hit,
    output logic               flush_req,
    output logic               wb_req,
    output logic [PADDR_W-1:0] wb_addr
);
    logic             is_cmo;
    cmo_cmd_t         cmd;
    logic [IDX_W-1:0] line_idx;
    logic             sel_dcache;
    logic             clr_en;
    logic [1:0]       rd_valid_c;
    logic [1:0]       rd_dirty_c;
    logic [TAG_W-1:0] rd_tag_c [2];
    logic             unused_bits;

    assign unused_bits = ^{instr[25:21], instr[15:0],
                           vaddr[VADDR_W-1:OFF_W+IDX_W], vaddr[OFF_W-1:0],
                           fill_vaddr[VADDR_W-1:OFF_W+IDX_W], fill_vaddr[OFF_W-1:0]};

    cmo_decode u_decode (
        .opcode (instr[31:26]),
        .op_sel (instr[20:16]),
        .is_cmo (is_cmo),
        .cmd    (cmd)
    );

    for (genvar c = 0; c < 2; c++) begin : g_cache
        cmo_tag_store #(
            .LINES (LINES),
            .TAG_W (TAG_W)
        ) u_tags (
            .clk        (clk),
            .rst        (rst),
            .fill_en    (fill_en && (fill_dcache == 1'(c))),
            .fill_idx   (fill_vaddr[OFF_W +: IDX_W]),
            .fill_tag   (fill_ptag),
            .fill_dirty (fill_dirty),
            .clr_en     (clr_en && (sel_dcache == 1'(c))),
            .clr_idx    (line_idx),
            .rd_idx     (line_idx),
            .rd_valid   (rd_valid_c[c]),
            .rd_dirty   (rd_dirty_c[c]),
            .rd_tag     (rd_tag_c[c])
        );
    end

    cmo_fsm #(
        .TAG_W (TAG_W),
        .IDX_W (IDX_W),
        .OFF_W (OFF_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .is_cmo      (is_cmo),
        .cmd_in      (cmd),
        .idx_in      (vaddr[OFF_W +: IDX_W]),
        .ptag_in     (ptag),
        .rd_valid    (rd_valid_c[sel_dcache]),
        .rd_dirty    (rd_dirty_c[sel_dcache]),
        .rd_tag      (rd_tag_c[sel_dcache]),
        .wb_ack      (wb_ack),
        .line_idx    (line_idx),
        .sel_dcache  (sel_dcache),
        .clr_en      (clr_en),
        .busy        (busy),
        .done        (done),
        .done_hit    (done_hit),
        .flush_req   (flush_req),
        .wb_req      (wb_req),
        .wb_addr     (wb_addr)
    );

    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !busy && !done && instr_valid && !is_cmo |=> !busy && !done); // R1
endmodule

// File: tb/cache_maint_ctrl_test.sv
`timescale 1ns/1ps
module cache_maint_ctrl_test;
    localparam int LINES = 16, TAG_W = 20, IDX_W = 4, OFF_W = 4, PADDR_W = 28;

    logic clk = 1'b0, rst = 1'b1;
    logic instr_valid = 0, fill_en = 0, fill_dcache = 0, fill_dirty = 0, wb_ack = 0;
    logic [31:0] instr = 0, vaddr = 0, fill_vaddr = 0;
    logic [TAG_W-1:0] ptag = 0, fill_ptag = 0;
    logic busy, done, done_hit, flush_req, wb_req;
    logic [PADDR_W-1:0] wb_addr;

    int n_chk = 0, n_bad = 0;
    logic mv [2][LINES];
    logic md [2][LINES];
    logic [TAG_W-1:0] mt [2][LINES];

    always #2.5 clk = ~clk;

    cache_maint_ctrl uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr), .vaddr(vaddr),
        .ptag(ptag), .fill_en(fill_en), .fill_dcache(fill_dcache), .fill_vaddr(fill_vaddr),
        .fill_ptag(fill_ptag), .fill_dirty(fill_dirty), .wb_ack(wb_ack), .busy(busy),
        .done(done), .done_hit(done_hit), .flush_req(flush_req), .wb_req(wb_req),
        .wb_addr(wb_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected command {dcache, by_index, write_only}, 0 = no operation
    function automatic logic [2:0] exp_cmd(input logic [4:0] code);
        case (code)
            5'b00000: return 3'b011;
            5'b01000: return 3'b011;
            5'b10000: return 3'b001;
            5'b00001: return 3'b110;
            5'b01001: return 3'b111;
            5'b10001: return 3'b101;
            5'b10101: return 3'b100;
            default:  return 3'b000;
        endcase
    endfunction

    function automatic string op_req(input logic [4:0] code);
        case (code)
            5'b00000, 5'b00001, 5'b10000: return (code == 5'b10000) ? "R5" : "R3";
            5'b01000, 5'b01001: return "R4";
            5'b10001: return "R5";
            5'b10101: return "R6";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [31:0] mk_va(input int idx);
        return {$urandom() & 32'hFFFFFF00} | (32'(idx) << OFF_W) | ($urandom() & 32'hF);
    endfunction

    task automatic fill(input bit dc, input int idx, input logic [TAG_W-1:0] t, input bit dty);
        fill_en = 1; fill_dcache = dc; fill_vaddr = mk_va(idx); fill_ptag = t; fill_dirty = dty;
        @(negedge clk);
        fill_en = 0;
        mv[dc][idx] = 1; md[dc][idx] = dty; mt[dc][idx] = t;
    endtask

    task automatic foreign(input logic [5:0] opc, input logic [4:0] code, input int idx);
        bit quiet = 1;
        instr = {opc, 5'd3, code, 16'h1234}; vaddr = mk_va(idx); instr_valid = 1;
        @(negedge clk);
        instr_valid = 0;
        for (int k = 0; k < 4; k++) begin
            if (busy || done) quiet = 0;
            @(negedge clk);
        end
        check(quiet, "R1 foreign opcode", {30'd0, busy, done}, 0);
    endtask

    task automatic op(input logic [4:0] code, input int idx, input logic [TAG_W-1:0] t,
                      input bit inject, input int ackdly);
        logic [2:0] c = exp_cmd(code);
        bit dc = c[2], ix = c[1], wo = c[0];
        bit nop = (c == 3'b000);
        bit e_hit, e_wb, e_fl;
        logic [PADDR_W-1:0] e_addr;
        bit got_done = 0, wb_seen = 0, addr_ok = 1, hit_s = 0, fl_s = 0;
        int wbc = 0, cyc = 0;
        logic [PADDR_W-1:0] bad_addr = 0;
        string rq = op_req(code);
        e_hit = !nop && mv[dc][idx] && (ix || mt[dc][idx] == t);
        e_wb  = e_hit && !wo && md[dc][idx];
        e_fl  = !nop && !dc;
        e_addr = {mt[dc][idx], 4'(idx), 4'h0};
        instr = {6'b101111, 5'($urandom()), code, 16'($urandom())};
        vaddr = mk_va(idx); ptag = t; instr_valid = 1;
        @(negedge clk);
        if (nop) check(done && !busy, "R2 nop completes next cycle", {30'd0, done, busy}, 2);
        else     check(busy && !done, "R9 busy after accept", {30'd0, busy, done}, 2);
        while (!got_done && cyc < 60) begin
            instr_valid = inject && cyc == 0;
            if (inject) begin
                instr = {6'b101111, 5'd0, 5'b00001, 16'h0}; vaddr = mk_va((idx + 1) % LINES);
            end
            if (done) begin
                got_done = 1; hit_s = done_hit; fl_s = flush_req; wb_ack = 0;
            end else if (wb_req) begin
                if (wb_addr != e_addr) begin addr_ok = 0; bad_addr = wb_addr; end
                wb_seen = 1;
                wb_ack = (wbc == ackdly);
                wbc++;
            end else begin
                wb_ack = 0;
            end
            if (!got_done) begin @(negedge clk); cyc++; end
        end
        instr_valid = 0; wb_ack = 0;
        check(got_done, {"R9 done reached ", rq}, 32'(got_done), 1);
        check(hit_s == e_hit, {"R11 done_hit ", rq}, 32'(hit_s), 32'(e_hit));
        check(wb_seen == e_wb, {"R7 writeback issued ", rq}, 32'(wb_seen), 32'(e_wb));
        if (e_wb) check(addr_ok && wbc == ackdly + 1, "R7 wb_addr held until ack",
                        32'(bad_addr), 32'(e_addr));
        check(fl_s == e_fl, "R8 flush_req", 32'(fl_s), 32'(e_fl));
        @(negedge clk);
        check(!done && !busy, "R9 done lasts one cycle", {30'd0, done, busy}, 0);
        if (e_hit) begin mv[dc][idx] = 0; md[dc][idx] = 0; mt[dc][idx] = '0; end
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        for (int d = 0; d < 2; d++)
            for (int i = 0; i < LINES; i++) begin mv[d][i] = 0; md[d][i] = 0; mt[d][i] = '0; end
        repeat (4) @(negedge clk);
        rst = 0;
        check(!busy && !done && !wb_req && !flush_req, "R10 reset outputs",
              {28'd0, busy, done, wb_req, flush_req}, 0);
        op(5'b10101, 0, '0, 0, 0);   // R10 empty after reset: miss
        op(5'b00000, 1, '0, 0, 0);   // R10 index on empty line
        // R3 index writeback invalidate on dirty line
        fill(1, 3, 20'h5, 1);
        op(5'b00001, 3, 20'hABC, 0, 2);
        op(5'b10101, 3, 20'h5, 0, 0);
        // R4 store tag on dirty data line: no writeback
        fill(1, 4, 20'h6, 1);
        op(5'b01001, 4, 20'h6, 0, 0);
        op(5'b10101, 4, 20'h6, 0, 0);
        // R5 miss leaves line, then R6 hit with writeback
        fill(1, 5, 20'h7, 1);
        op(5'b10001, 5, 20'h8, 0, 0);
        op(5'b10101, 5, 20'h7, 0, 1);
        // R5 data hit invalidate on dirty line: no writeback
        fill(1, 9, 20'h11, 1);
        op(5'b10001, 9, 20'h11, 0, 0);
        // R6 clean hit: clear without writeback
        fill(1, 6, 20'h9, 0);
        op(5'b10101, 6, 20'h9, 0, 0);
        op(5'b10101, 6, 20'h9, 0, 0);
        // R8 instruction cache operations
        fill(0, 2, 20'h3, 1);
        op(5'b10000, 2, 20'h4, 0, 0);
        op(5'b10000, 2, 20'h3, 0, 0);
        op(5'b00000, 2, 20'h3, 0, 0);
        fill(0, 2, 20'h3, 0);
        op(5'b01000, 2, 20'h0, 0, 0);
        op(5'b10000, 2, 20'h3, 0, 0);
        // R2 unsupported code is a nop
        fill(1, 10, 20'h22, 1);
        op(5'b11111, 10, 20'h22, 0, 0);
        op(5'b00101, 10, 20'h22, 0, 0);
        op(5'b10101, 10, 20'h22, 0, 0);
        // R1 wrong major opcode
        fill(1, 11, 20'h33, 1);
        foreign(6'b101110, 5'b00001, 11);
        foreign(6'b001111, 5'b10101, 11);
        op(5'b10101, 11, 20'h33, 0, 0);
        // R9 command injected while busy is ignored
        fill(1, 7, 20'h1, 1);
        fill(1, 8, 20'h2, 1);
        op(5'b10101, 7, 20'h1, 1, 3);
        op(5'b10101, 8, 20'h2, 0, 0);
        // random mix
        for (int it = 0; it < 400; it++) begin
            int idx = int'($urandom_range(0, LINES - 1));
            logic [TAG_W-1:0] t = TAG_W'($urandom_range(0, 3));
            int sel = int'($urandom_range(0, 9));
            if (sel < 3) fill(1'($urandom_range(0, 1)), idx, t, 1'($urandom_range(0, 1)));
            else begin
                logic [4:0] codes [8] = '{5'b00000, 5'b01000, 5'b10000, 5'b00001,
                                          5'b01001, 5'b10001, 5'b10101, 5'b11011};
                op(codes[$urandom_range(0, 7)], idx, t, 1'($urandom_range(0, 1)),
                   int'($urandom_range(0, 3)));
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule